// File: doc/BRIEF.md
# Frame-Gated Serial Word Receiver

This block is the receive half of a synchronous serial port. It works in the system clock domain. A one-cycle `bit_tick` pulse marks each active bit-clock edge. On such an edge a high `fsync` marks the first bit of a word. Bits arrive most significant first. Once the selected number of bits has arrived, the word is left-justified into a 24-bit holding register and a full flag is raised. If the host has not read the previous word when a new one lands, an overrun flag is raised.

The receive enable never cuts a word short. Dropping it in the middle of a word lets that word finish and land in the holding register.

In network mode, one frame sync opens a frame of back-to-back words. Any drop of the enable inside that frame ends reception once the current word is done. Raising the enable again has no effect until the next frame sync. Normal and on-demand modes behave the same on the receive side: every word needs its own frame sync with the enable high.

Top module: `serial_rx_gate`

## Requirements
- R1: After reset `rx_data` is 0 and `rx_full` and `rx_ovr` are both 0.
- R2: Word length code `wlen` selects 0=8, 1=12, 2=16 or 3=24 bits. Bits are taken most significant first on `bit_tick` cycles. The word is placed left-justified in `rx_data` with the low bits zero. `rx_data` and `rx_full`=1 are visible in the cycle after the tick that carried the last bit, and `rx_data` changes at no other time.
- R3: In normal mode (`mode`=0), on-demand mode (`mode`=2) and `mode`=3, a word begins only on a tick with `fsync`=1 and `rx_en`=1. With `rx_en`=0, or without a frame sync, nothing is transferred.
- R4: Clearing `rx_en` after a word has begun does not stop that word: its remaining bits are shifted in and it is transferred.
- R5: In network mode (`mode`=1), a tick with `fsync`=1 and `rx_en`=1 starts a frame. Further words then follow back-to-back without frame sync while `rx_en` stays 1.
- R6: In network mode, if `rx_en` is 0 in any cycle of a frame, the word in progress is still completed. No further word starts before the next tick that has `fsync`=1, even if `rx_en` is set again.
- R7: A frame sync that arrives while a word is in progress is ignored; the word is neither restarted nor shortened.
- R8: A one-cycle `host_rd` clears `rx_full` and `rx_ovr` in the next cycle. If a transfer happens in the same cycle, `rx_full` stays 1.
- R9: A transfer while `rx_full`=1 and without `host_rd` in that cycle sets `rx_ovr`. The new word replaces the old one.
- R10: The word length is latched at the start of each word; changing `wlen` mid-word has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking the active bit-clock edge |
| sdata | input | 1 | Serial data, sampled on `bit_tick` |
| fsync | input | 1 | Frame sync, sampled on `bit_tick`, marks first bit |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | 0 normal, 1 network, 2 on-demand, 3 as normal |
| wlen | input | 2 | Word length code (8/12/16/24 bits) |
| host_rd | input | 1 | Host read strobe of the holding register |
| rx_data | output | 24 | Left-justified received word |
| rx_full | output | 1 | Holding register holds an unread word |
| rx_ovr | output | 1 | A word was overwritten before it was read |

## Verification
On every cycle the assertions check the holding register's flag protocol: full after a transfer, clear after a read, overrun on an unread overwrite, and data steady between transfers. They also check that a word never starts without the enable and frame sync the mode demands, and that a network frame stays idle after an enable drop. Other behaviour shows only in the bench's scenarios against its reference model: that a word finishes after the enable falls, that the latched length and a stray mid-word frame sync leave the word intact, and the exact bit order and justification of each word length.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RXM_NORMAL   = 2'd0,
    RXM_NETWORK  = 2'd1,
    RXM_ONDEMAND = 2'd2,
    RXM_ALT      = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    WL_8  = 2'd0,
    WL_12 = 2'd1,
    WL_16 = 2'd2,
    WL_24 = 2'd3
  } wlen_code_e;

  // number of bits in a word for a given length code
  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      WL_8:    return 8;
      WL_12:   return 12;
      WL_16:   return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic is_network(input logic [1:0] m);
    return (m == RXM_NETWORK);
  endfunction

endpackage

// File: rtl/serial_rx_frame_ctl.sv
module serial_rx_frame_ctl
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       fsync,
  input  logic       rx_en,
  input  logic [1:0] mode,
  input  logic       busy,
  output logic       word_start,
  output logic       net_run
);

  logic net_mode;
  logic norm_go;
  logic net_go;

  assign net_mode = is_network(mode);

  // normal / on-demand: every word needs its own frame sync and the enable
  assign norm_go = !net_mode && fsync && rx_en;
  // network: a frame sync opens the frame, then words run back-to-back
  assign net_go  = net_mode && rx_en && (fsync || net_run);

  assign word_start = bit_tick && !busy && (norm_go || net_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      net_run <= 1'b0;
    end else if (!net_mode || !rx_en) begin
      net_run <= 1'b0;
    end else if (bit_tick && fsync) begin
      net_run <= 1'b1;
    end
  end

endmodule

// File: rtl/serial_rx_shift.sv
module serial_rx_shift
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              sdata,
  input  logic              word_start,
  input  logic [1:0]        wlen,
  output logic              busy,
  output logic              word_done,
  output logic [DATA_W-1:0] word_out
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nx;
  logic [CNT_W-1:0]  len_q;

  function automatic logic [CNT_W-1:0] len_of(input logic [1:0] code);
    return CNT_W'(word_bits(code));
  endfunction

  // place the n received bits at the top of the register
  function automatic logic [DATA_W-1:0] justify(input logic [DATA_W-1:0] a,
                                                input logic [CNT_W-1:0]  n);
    logic [CNT_W-1:0] sh;
    sh = CNT_W'(DATA_W) - n;
    return a << sh;
  endfunction

  assign acc_nx    = {acc_q[DATA_W-2:0], sdata};
  assign cnt_nx    = cnt_q + 1'b1;
  assign word_done = busy && bit_tick && (cnt_nx == len_q);
  assign word_out  = justify(acc_nx, len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      acc_q <= '0;
      cnt_q <= '0;
      len_q <= len_of(WL_8);
    end else if (word_start) begin
      busy  <= 1'b1;
      acc_q <= {{(DATA_W-1){1'b0}}, sdata};
      cnt_q <= CNT_W'(1);
      len_q <= len_of(wlen);
    end else if (busy && bit_tick) begin
      acc_q <= acc_nx;
      cnt_q <= cnt_nx;
      if (word_done) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [DATA_W-1:0] word_in,
  input  logic              host_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_ovr
);

  logic lost;
  assign lost = word_done && rx_full && !host_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (word_done) rx_data <= word_in;
      if (word_done)    rx_full <= 1'b1;
      else if (host_rd) rx_full <= 1'b0;
      if (lost)         rx_ovr <= 1'b1;
      else if (host_rd) rx_ovr <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx_gate.sv
module serial_rx_gate #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              sdata,
  input  logic              fsync,
  input  logic              rx_en,
  input  logic [1:0]        mode,
  input  logic [1:0]        wlen,
  input  logic              host_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_ovr
);

  // named internal events, observed by the checker
  logic              word_start;
  logic              word_done;
  logic              busy;
  logic              net_run;
  logic [DATA_W-1:0] word_bus;

  serial_rx_frame_ctl u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .fsync      (fsync),
    .rx_en      (rx_en),
    .mode       (mode),
    .busy       (busy),
    .word_start (word_start),
    .net_run    (net_run)
  );

  serial_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .sdata      (sdata),
    .word_start (word_start),
    .wlen       (wlen),
    .busy       (busy),
    .word_done  (word_done),
    .word_out   (word_bus)
  );

  serial_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .word_in   (word_bus),
    .host_rd   (host_rd),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .rx_ovr    (rx_ovr)
  );

endmodule

// File: rtl/serial_rx_gate_chk.sv
module serial_rx_gate_chk #(
  parameter int unsigned DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_tick,
  input logic              fsync,
  input logic              rx_en,
  input logic [1:0]        mode,
  input logic              host_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              rx_ovr,
  input logic              word_start,
  input logic              word_done
);

  // set by any enable drop in network mode, cleared by a fresh frame start
  logic dropped;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          dropped <= 1'b0;
    else if (mode == 2'd1 && !rx_en)     dropped <= 1'b1;
    else if (bit_tick && fsync && rx_en) dropped <= 1'b0;
  end

  AST_FULL_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rx_full); // R2

  AST_XFER_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> bit_tick); // R2

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(rx_data)); // R2

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && mode != 2'd1) |-> (rx_en && fsync)); // R3

  AST_NET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && mode == 2'd1) |-> rx_en); // R5

  AST_NET_IDLE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && mode == 2'd1 && !fsync) |-> !dropped); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !word_done) |=> (!rx_full && !rx_ovr)); // R8

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_full && !host_rd) |=> rx_ovr); // R9

endmodule

bind serial_rx_gate serial_rx_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_tick   (bit_tick),
  .fsync      (fsync),
  .rx_en      (rx_en),
  .mode       (mode),
  .host_rd    (host_rd),
  .rx_data    (rx_data),
  .rx_full    (rx_full),
  .rx_ovr     (rx_ovr),
  .word_start (word_start),
  .word_done  (word_done)
);

// File: tb/test_serial_rx_gate.sv
module test_serial_rx_gate;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        sdata = 1'b0;
  logic        fsync = 1'b0;
  logic        rx_en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  wlen = 2'd0;
  logic        host_rd = 1'b0;
  logic [23:0] rx_data;
  logic        rx_full;
  logic        rx_ovr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  serial_rx_gate i_serial_rx_gate (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sdata(sdata),
    .fsync(fsync), .rx_en(rx_en), .mode(mode), .wlen(wlen),
    .host_rd(host_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr)
  );

  // ---------------- behavioural reference model ----------------
  bit  m_bits[$];
  int  m_need = 0;
  bit  m_active = 0;
  bit  m_frame = 0;
  int  m_data = 0;
  bit  m_full = 0;
  bit  m_ovr = 0;

  function automatic int len_for(input logic [1:0] c);
    if (c == 2'd0) return 8;
    if (c == 2'd1) return 12;
    if (c == 2'd2) return 16;
    return 24;
  endfunction

  always @(posedge clk) begin
    bit landed;
    int w;
    landed = 0;
    if (!rst_n) begin
      m_bits.delete(); m_active = 0; m_frame = 0;
      m_data = 0; m_full = 0; m_ovr = 0;
    end else begin
      if (bit_tick) begin
        if (m_active) begin
          m_bits.push_back(sdata);
          if (m_bits.size() == m_need) begin
            landed = 1;
            m_active = 0;
          end
        end else if ((mode != 2'd1 && fsync && rx_en) ||
                     (mode == 2'd1 && rx_en && (fsync || m_frame))) begin
          m_active = 1;
          m_bits.delete();
          m_bits.push_back(sdata);
          m_need = len_for(wlen);
        end
      end
      if (mode != 2'd1 || !rx_en) m_frame = 0;
      else if (bit_tick && fsync) m_frame = 1;
      if (host_rd) m_ovr = 0;
      if (landed) begin
        w = 0;
        for (int i = 0; i < 24; i++) w = (w << 1) | ((i < m_need) ? int'(m_bits[i]) : 0);
        m_data = w & 32'hFFFFFF;
        if (m_full && !host_rd) m_ovr = 1;
        m_full = 1;
      end else if (host_rd) m_full = 0;
    end
  end

  // ---------------- checks ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(rx_data == m_data[23:0], "R2 model rx_data", int'(rx_data), m_data);
      chk(rx_full == m_full, "R8 model rx_full", int'(rx_full), int'(m_full));
      chk(rx_ovr == m_ovr, "R9 model rx_ovr", int'(rx_ovr), int'(m_ovr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick_bit(input bit sd, input bit fs, input bit rd);
    @(negedge clk);
    bit_tick = 1'b1; sdata = sd; fsync = fs; host_rd = rd;
    @(negedge clk);
    bit_tick = 1'b0; fsync = 1'b0; host_rd = 1'b0;
  endtask

  task automatic send_word(input int val, input int n, input bit fs, input bit rd_last);
    for (int i = 0; i < n; i++)
      tick_bit(val[n-1-i], fs && (i == 0), rd_last && (i == n-1));
  endtask

  task automatic read_reg();
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  function automatic int just(input int val, input int n);
    return (val << (24 - n)) & 32'hFFFFFF;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rx_data == 0 && !rx_full && !rx_ovr, "R1 reset state",
        int'({rx_full, rx_ovr, rx_data}), 0);
    rst_n = 1'b1;
    rx_en = 1'b1; mode = 2'd0;

    // R2: each word length, MSB first, left-justified
    wlen = 2'd0; send_word(32'hA5, 8, 1, 0);
    chk(rx_data == 24'hA50000 && rx_full, "R2 8-bit word", int'(rx_data), 32'hA50000);
    read_reg();
    chk(!rx_full && !rx_ovr, "R8 read clears full", int'(rx_full), 0);
    wlen = 2'd1; send_word(32'hABC, 12, 1, 0);
    chk(rx_data == 24'hABC000, "R2 12-bit word", int'(rx_data), 32'hABC000);
    read_reg();
    wlen = 2'd2; send_word(32'h1234, 16, 1, 0);
    chk(rx_data == 24'h123400, "R2 16-bit word", int'(rx_data), 32'h123400);
    read_reg();
    wlen = 2'd3; send_word(32'h5A5A5B, 24, 1, 0);
    chk(rx_data == 24'h5A5A5B, "R2 24-bit word", int'(rx_data), 32'h5A5A5B);
    read_reg();

    // R3: disabled receiver and missing frame sync
    wlen = 2'd0; rx_en = 1'b0;
    send_word(32'h3C, 8, 1, 0);
    chk(!rx_full && rx_data == 24'h5A5A5B, "R3 disabled no transfer", int'(rx_data), 32'h5A5A5B);
    rx_en = 1'b1;
    send_word(32'h3C, 8, 0, 0);
    chk(!rx_full, "R3 no fsync no word", int'(rx_full), 0);
    mode = 2'd2;
    send_word(32'h3C, 8, 1, 0);
    chk(rx_full && rx_data == 24'h3C0000, "R3 on-demand receive", int'(rx_data), 32'h3C0000);
    read_reg();
    mode = 2'd0;

    // R4: enable dropped mid-word
    for (int i = 0; i < 8; i++) begin
      if (i == 3) rx_en = 1'b0;
      tick_bit(i[0], i == 0, 0);
    end
    chk(rx_full && rx_data == 24'h550000, "R4 word completes after disable",
        int'(rx_data), 32'h550000);
    read_reg();
    rx_en = 1'b1;

    // R7: stray frame sync mid-word ignored
    for (int i = 0; i < 8; i++) tick_bit(32'hC3 >> (7 - i), (i == 0) || (i == 4), 0);
    chk(rx_full && rx_data == 24'hC30000, "R7 mid-word fsync ignored", int'(rx_data), 32'hC30000);
    read_reg();

    // R10: length change mid-word ignored
    for (int i = 0; i < 8; i++) begin
      if (i == 2) wlen = 2'd3;
      tick_bit(32'h96 >> (7 - i), i == 0, 0);
    end
    chk(rx_full && rx_data == 24'h960000, "R10 length latched", int'(rx_data), 32'h960000);
    wlen = 2'd0;

    // R9: overrun on unread register, new word replaces old
    send_word(32'h81, 8, 1, 0);
    chk(rx_ovr && rx_full && rx_data == 24'h810000, "R9 overrun set", int'({rx_ovr, rx_data}), 32'h1810000);
    read_reg();
    chk(!rx_ovr && !rx_full, "R8 read clears overrun", int'(rx_ovr), 0);

    // R8: transfer and read in the same cycle
    send_word(32'h11, 8, 1, 0);
    send_word(32'h22, 8, 1, 1);
    chk(rx_full && !rx_ovr && rx_data == 24'h220000, "R8 same-cycle transfer wins",
        int'({rx_full, rx_ovr}), 2);
    read_reg();

    // R5: network mode back-to-back words
    mode = 2'd1;
    send_word(32'h4D, 8, 1, 0);
    chk(rx_data == 24'h4D0000, "R5 first frame word", int'(rx_data), 32'h4D0000);
    read_reg();
    send_word(32'hB2, 8, 0, 0);
    chk(rx_full && rx_data == 24'hB20000, "R5 follow-on word", int'(rx_data), 32'hB20000);
    read_reg();

    // R6: enable pulsed low mid-frame
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); rx_en = 1'b1;
      end
      tick_bit(32'hE7 >> (7 - i), 0, 0);
    end
    chk(rx_full && rx_data == 24'hE70000, "R6 current word finishes", int'(rx_data), 32'hE70000);
    read_reg();
    send_word(32'h18, 8, 0, 0);
    chk(!rx_full && rx_data == 24'hE70000, "R6 idle until next frame", int'(rx_full), 0);
    send_word(32'h6F, 8, 1, 0);
    chk(rx_full && rx_data == 24'h6F0000, "R6 resumes at frame sync", int'(rx_data), 32'h6F0000);
    read_reg();

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule